// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by reading a three-level translation table held in memory. A translation starts when the requester presents a virtual address together with the byte address of the top-level table. The walker then issues one 4-byte entry read per level over a single-outstanding read port. Each level's read address is formed from the entry returned by the level above. The walk ends with either a physical address or a fault that names the level at which an entry was marked invalid.

The top-level table has four entries, indexed by virtual address bits 31..30. The second and third levels are 2 KB tables of 512 entries each, indexed by bits 29..21 and 20..12. These lower tables may start on any 2 KB boundary, not only on a page boundary. For that reason, entries at the first two levels carry a 25-bit pointer counted in 2 KB units. Third-level entries carry a 24-bit frame number counted in 4 KB units. Bits 11..0 of the virtual address pass straight through as the page offset.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, and mem_req_valid, done, fault, fault_level and paddr are all 0.
- R2: The first read goes to the top-table address with its low 4 bits forced to zero, plus 4 × vaddr[31:30]. The low 4 bits of root_base have no effect.
- R3: The second read goes to (first entry bits 24..0) × 2048 + 4 × vaddr[29:21].
- R4: The third read goes to (second entry bits 24..0) × 2048 + 4 × vaddr[20:12].
- R5: When the third entry is valid, paddr becomes (third entry bits 23..0) × 4096 + vaddr[11:0], with fault = 0 and fault_level = 0.
- R6: Entry bit 31 is the valid flag. When a level returns an entry with bit 31 clear, the walk stops with fault = 1 and fault_level set to the level (1, 2 or 3). No further read is made, and paddr keeps its previous value.
- R7: mem_req_valid stays high with an unchanged mem_req_addr until mem_req_ready is seen. After a read is accepted, no new read is issued until its response (mem_rsp_valid) arrives.
- R8: done is high for exactly one cycle, in the cycle after the deciding response. paddr, fault and fault_level change only at such a completion.
- R9: req_ready is low from the accepting cycle until done. While req_ready is low, req_valid, req_vaddr and root_base have no effect.
- R10: Entry bits 30..25 at levels 1 and 2, and bits 30..24 at level 3, do not affect any address or result.
- R11: Raising rst during a walk returns the walker to idle with no read request pending. A response that arrives afterwards produces no done.
- R12: A request presented in the cycle where done is high is accepted, and its first read follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| root_base | input | 36 | Byte address of the top-level table (16-byte aligned) |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 36 | Byte address of the entry read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry returned by memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk ended on an invalid entry |
| fault_level | output | 2 | Level of the invalid entry, 0 when no fault |
| paddr | output | 36 | Last successful physical address |

## Verification
The pair that can coincide is a completion pulse and the acceptance of the next translation. The bench provokes this by raising a new request in the very cycle in which done is seen. The per-clock reference model must then see the old result appear, idle last for only that single cycle, and the next read begin in the following cycle. The bench also provokes a second overlap: a completion due one cycle after a response that lands just as reset is released, with a stray response that must not produce done. Throughout, memory latency and request stalls vary from cycle to cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } ptw_state_e;

   typedef logic [1:0] ptw_lvl_t;

   localparam ptw_lvl_t LVL_TOP  = 2'd1;
   localparam ptw_lvl_t LVL_LEAF = 2'd3;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen import ptw_pkg::*; #(
   parameter int VA_W     = 32,
   parameter int PA_W     = 36,
   parameter int OFF_W    = 12,
   parameter int L1_IDX_W = 2,
   parameter int LX_IDX_W = 9,
   parameter int PTE_SH   = 2
)(
   input  ptw_lvl_t          lvl,
   input  logic [VA_W-1:0]   va,
   input  logic [PA_W-1:0]   base,
   output logic [PA_W-1:0]   pte_addr
);
   localparam int IDX_W = (L1_IDX_W > LX_IDX_W) ? L1_IDX_W : LX_IDX_W;
   localparam int MID_LO = OFF_W + LX_IDX_W;

   logic [IDX_W-1:0] idx;
   logic             unused_off;

   generate
      if (VA_W != L1_IDX_W + 2 * LX_IDX_W + OFF_W) begin : g_bad_split
         $error("ptw_addr_gen: index fields do not cover the virtual address");
      end
   endgenerate

   always_comb begin
      case (lvl)
         2'd1:    idx = IDX_W'(va[VA_W-1 -: L1_IDX_W]);
         2'd2:    idx = IDX_W'(va[MID_LO +: LX_IDX_W]);
         default: idx = IDX_W'(va[OFF_W +: LX_IDX_W]);
      endcase
   end

   assign pte_addr   = base + (PA_W'(idx) << PTE_SH);
   assign unused_off = ^va[OFF_W-1:0];

endmodule

// File: rtl/ptw_pte_dec.sv
module ptw_pte_dec #(
   parameter int PTE_W     = 32,
   parameter int PA_W      = 36,
   parameter int VALID_BIT = 31,
   parameter int TBL_SH    = 11,
   parameter int OFF_W     = 12
)(
   input  logic [PTE_W-1:0]      pte,
   output logic                  pte_ok,
   output logic [PA_W-1:0]       next_base,
   output logic [PA_W-OFF_W-1:0] frame
);
   localparam int PTR_W   = PA_W - TBL_SH;
   localparam int FRAME_W = PA_W - OFF_W;
   localparam int HI_W    = (PTR_W > FRAME_W) ? PTR_W : FRAME_W;

   generate
      if (VALID_BIT < HI_W || VALID_BIT >= PTE_W) begin : g_bad_valid
         $error("ptw_pte_dec: valid flag overlaps the pointer field");
      end
      if (PTE_W > HI_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^pte[PTE_W-1:HI_W];
      end
   endgenerate

   assign pte_ok    = pte[VALID_BIT];
   assign next_base = {pte[PTR_W-1:0], {TBL_SH{1'b0}}};
   assign frame     = pte[FRAME_W-1:0];

endmodule

// File: rtl/pt_walker.sv
module pt_walker import ptw_pkg::*; #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 36,
   parameter int OFF_W     = 12,
   parameter int L1_IDX_W  = 2,
   parameter int LX_IDX_W  = 9,
   parameter int PTE_W     = 32,
   parameter int VALID_BIT = 31
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [PA_W-1:0] root_base,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_req_addr,
   input  logic            mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rsp_data,
   output logic            done,
   output logic            fault,
   output logic [1:0]      fault_level,
   output logic [PA_W-1:0] paddr
);
   localparam int PTE_SH  = $clog2(PTE_W / 8);
   localparam int TBL_SH  = LX_IDX_W + PTE_SH;
   localparam int ROOT_SH = L1_IDX_W + PTE_SH;
   localparam int FRAME_W = PA_W - OFF_W;

   generate
      if (PTE_W % 8 != 0 || (1 << PTE_SH) * 8 != PTE_W) begin : g_bad_pte
         $error("pt_walker: entry width must be a power-of-two byte count");
      end
      if (VA_W != L1_IDX_W + 2 * LX_IDX_W + OFF_W) begin : g_bad_va
         $error("pt_walker: virtual address split is inconsistent");
      end
      if (TBL_SH >= PA_W || OFF_W >= PA_W) begin : g_bad_pa
         $error("pt_walker: physical address too narrow");
      end
   endgenerate

   ptw_state_e          state;
   ptw_lvl_t            lvl_q;
   logic [VA_W-1:0]     va_q;
   logic [PA_W-1:0]     base_q;
   logic [PA_W-1:0]     paddr_q;
   logic                fault_q;
   logic [1:0]          flvl_q;
   logic                done_q;

   logic [PA_W-1:0]     root_aligned;
   logic [PA_W-1:0]     pte_addr;
   logic                pte_ok;
   logic [PA_W-1:0]     next_base;
   logic [FRAME_W-1:0]  frame;
   logic                unused_root;

   assign root_aligned = {root_base[PA_W-1:ROOT_SH], {ROOT_SH{1'b0}}};
   assign unused_root  = ^root_base[ROOT_SH-1:0];

   ptw_addr_gen #(
      .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W),
      .L1_IDX_W(L1_IDX_W), .LX_IDX_W(LX_IDX_W), .PTE_SH(PTE_SH)
   ) i_addr_gen (
      .lvl(lvl_q), .va(va_q), .base(base_q), .pte_addr(pte_addr)
   );

   ptw_pte_dec #(
      .PTE_W(PTE_W), .PA_W(PA_W), .VALID_BIT(VALID_BIT),
      .TBL_SH(TBL_SH), .OFF_W(OFF_W)
   ) i_pte_dec (
      .pte(mem_rsp_data), .pte_ok(pte_ok), .next_base(next_base), .frame(frame)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_IDLE;
         lvl_q   <= LVL_TOP;
         va_q    <= '0;
         base_q  <= '0;
         paddr_q <= '0;
         fault_q <= 1'b0;
         flvl_q  <= 2'd0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= root_aligned;
                  lvl_q  <= LVL_TOP;
                  state  <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (mem_req_ready) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!pte_ok) begin
                     fault_q <= 1'b1;
                     flvl_q  <= lvl_q;
                     done_q  <= 1'b1;
                     state   <= ST_IDLE;
                  end else if (lvl_q == LVL_LEAF) begin
                     paddr_q <= {frame, va_q[OFF_W-1:0]};
                     fault_q <= 1'b0;
                     flvl_q  <= 2'd0;
                     done_q  <= 1'b1;
                     state   <= ST_IDLE;
                  end else begin
                     base_q <= next_base;
                     lvl_q  <= lvl_q + 2'd1;
                     state  <= ST_REQ;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign mem_req_valid = (state == ST_REQ);
   assign mem_req_addr  = pte_addr;
   assign done          = done_q;
   assign fault         = fault_q;
   assign fault_level   = flvl_q;
   assign paddr         = paddr_q;

   // checks kept beside the walk logic
   logic armed;
   logic rst_q;

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst) armed <= 1'b0;
      else     armed <= 1'b1;
   end

   always @(negedge clk) begin
      if (rst_q) begin
         assert_reset_idle_R11: assert (req_ready && !mem_req_valid && !done)
            else $error("walker not idle after reset");
      end
   end

   assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst || !armed)
      !done |-> ($stable(paddr) && $stable(fault) && $stable(fault_level)));

   assert_fault_level_R6: assert property (@(posedge clk) disable iff (rst)
      done |-> (fault ? (fault_level != 2'd0) : (fault_level == 2'd0)));

   assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !mem_req_valid);

   assert_accept_start_R12: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> (!req_ready && mem_req_valid));

endmodule

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [35:0] root_base;
   logic        mem_req_valid;
   logic        mem_req_ready;
   logic [35:0] mem_req_addr;
   logic        mem_rsp_valid;
   logic [31:0] mem_rsp_data;
   logic        done;
   logic        fault;
   logic [1:0]  fault_level;
   logic [35:0] paddr;

   always #4 clk = ~clk;

   pt_walker i_pt_walker (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .root_base(root_base),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr)
   );

   logic [31:0] mem [logic [35:0]];
   int checks = 0;
   int errors = 0;

   // reference model state
   bit          busy_m = 0;
   logic [35:0] exp_q[$];
   bit          final_sent = 0;
   logic [35:0] e_paddr;
   bit          e_fault;
   int          e_lvl;
   logic [35:0] cur_paddr = '0;
   bit          cur_fault = 0;
   int          cur_lvl = 0;
   bit          resp_pending = 0;
   int          wait_cnt = 0;
   bit          hs_armed = 0;
   logic [35:0] cap_addr;
   logic [31:0] rsp_data_r;
   int          stall = 0;
   int          rd_lvl = 0;
   bit          hold_chk = 0;
   logic [35:0] hold_addr;
   bit          stray_req = 0;
   bit          seen_reset = 0;

   task automatic chk(bit ok, string tag, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd(logic [35:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   task automatic build(logic [31:0] va, logic [35:0] root);
      logic [35:0] a;
      logic [31:0] p;
      exp_q.delete();
      e_fault = 0;
      e_lvl = 0;
      e_paddr = cur_paddr;
      a = {root[35:4], 4'h0} + 36'(va[31:30]) * 4;
      for (int l = 1; l <= 3; l++) begin
         exp_q.push_back(a);
         p = rd(a);
         if (!p[31]) begin
            e_fault = 1;
            e_lvl = l;
            break;
         end
         if (l == 3) e_paddr = 36'(p[23:0]) * 4096 + 36'(va[11:0]);
         else a = 36'(p[24:0]) * 2048 + 36'((l == 1) ? va[29:21] : va[20:12]) * 4;
      end
   endtask

   // fill the tables for one walk; bad_lvl > 0 leaves that level invalid
   task automatic map_walk(logic [35:0] root, logic [31:0] va, logic [24:0] p1,
                           logic [24:0] p2, logic [23:0] frm, int bad_lvl, bit junk);
      logic [35:0] a1, a2, a3;
      logic [31:0] j12, j3;
      j12 = junk ? 32'h7E00_0000 : 32'h0;
      j3  = junk ? 32'h7F00_0000 : 32'h0;
      a1 = {root[35:4], 4'h0} + 36'(va[31:30]) * 4;
      a2 = 36'(p1) * 2048 + 36'(va[29:21]) * 4;
      a3 = 36'(p2) * 2048 + 36'(va[20:12]) * 4;
      mem[a1] = (bad_lvl == 1) ? (j12 | {7'h0, p1}) : (32'h8000_0000 | j12 | {7'h0, p1});
      if (bad_lvl == 1) return;
      mem[a2] = (bad_lvl == 2) ? (j12 | {7'h0, p2}) : (32'h8000_0000 | j12 | {7'h0, p2});
      if (bad_lvl == 2) return;
      mem[a3] = (bad_lvl == 3) ? (j3 | {8'h0, frm}) : (32'h8000_0000 | j3 | {8'h0, frm});
   endtask

   // per-clock model, comparison and memory responder
   initial begin
      mem_req_ready = 0;
      mem_rsp_valid = 0;
      mem_rsp_data  = '0;
      forever begin
         @(negedge clk);
         if (rst) begin
            busy_m = 0; exp_q.delete(); resp_pending = 0; hs_armed = 0;
            final_sent = 0; hold_chk = 0; stall = 0;
            cur_paddr = '0; cur_fault = 0; cur_lvl = 0;
            mem_rsp_valid = 0; mem_req_ready = 0;
            chk(req_ready && !mem_req_valid && !done, seen_reset ? "R11 reset idle" : "R1 reset idle",
                {req_ready, mem_req_valid, done}, 3'b100);
            chk(fault == 0 && fault_level == 0 && paddr == 0, "R1 reset results",
                {fault, fault_level, paddr}, 0);
            seen_reset = 1;
         end else begin
            bit done_exp;
            done_exp = final_sent;
            final_sent = 0;
            if (done_exp) begin
               busy_m = 0;
               cur_paddr = e_paddr; cur_fault = e_fault; cur_lvl = e_lvl;
            end else if (req_valid && !busy_m) begin
               busy_m = 1;
               rd_lvl = 0;
               build(req_vaddr, root_base);
            end
            chk(req_ready == !busy_m, "R9 ready", req_ready, !busy_m);
            chk(done == done_exp, "R8 done pulse", done, done_exp);
            chk(paddr == cur_paddr, (done_exp && !e_fault) ? "R5 paddr" : "R8 paddr hold",
                paddr, cur_paddr);
            chk(fault == cur_fault && fault_level == 2'(cur_lvl), done_exp ? "R6 fault" : "R8 fault hold",
                {fault, fault_level}, {cur_fault, 2'(cur_lvl)});
            if (hold_chk)
               chk(mem_req_valid && mem_req_addr == hold_addr, "R7 request hold", mem_req_addr, hold_addr);

            mem_rsp_valid = 0;
            if (stray_req) begin
               mem_rsp_valid = 1;
               mem_rsp_data  = 32'h8000_0001;
               stray_req = 0;
            end
            if (hs_armed) begin
               hs_armed = 0;
               rd_lvl++;
               if (exp_q.size() > 0) begin
                  chk(cap_addr == exp_q[0], (rd_lvl == 1) ? "R2 level1 addr" :
                      (rd_lvl == 2) ? "R3 level2 addr" : "R4 level3 addr", cap_addr, exp_q[0]);
                  void'(exp_q.pop_front());
               end else begin
                  chk(0, "R6 read after end of walk", cap_addr, 0);
               end
               resp_pending = 1;
               wait_cnt = $urandom_range(0, 3);
               rsp_data_r = rd(cap_addr);
            end
            if (resp_pending) begin
               chk(!mem_req_valid, "R7 single outstanding", mem_req_valid, 0);
               if (wait_cnt == 0) begin
                  mem_rsp_valid = 1;
                  mem_rsp_data  = rsp_data_r;
                  resp_pending  = 0;
                  if (exp_q.size() == 0) final_sent = 1;
               end else begin
                  wait_cnt--;
               end
            end
            mem_req_ready = 0;
            hold_chk = 0;
            if (mem_req_valid && !resp_pending && !hs_armed) begin
               if (stall > 0) begin
                  stall--;
                  hold_chk = 1;
                  hold_addr = mem_req_addr;
               end else begin
                  mem_req_ready = 1;
                  hs_armed = 1;
                  cap_addr = mem_req_addr;
                  stall = $urandom_range(0, 2);
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   // called at negedge + 1 ns; returns at negedge + 1 ns after acceptance
   task automatic issue(logic [31:0] va, logic [35:0] root);
      req_valid = 1; req_vaddr = va; root_base = root;
      while (!req_ready) begin @(negedge clk); #1; end
      @(negedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wait_done();
      while (!done) begin @(negedge clk); #1; end
   endtask

   task automatic gap(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   localparam logic [31:0] VA1 = {2'b10, 9'h1A3, 9'h055, 12'hABC};
   localparam logic [31:0] VA2 = {2'b01, 9'h00F, 9'h1FF, 12'h123};
   localparam logic [31:0] VA3 = {2'b11, 9'h002, 9'h003, 12'h004};
   localparam logic [31:0] VAM = 32'hFFFF_FFFF;

   initial begin
      rst = 1; req_valid = 0; req_vaddr = '0; root_base = '0;
      map_walk(36'h0_0000_1000, VA1, 25'h0012345, 25'h0ABCDEF, 24'hC0FFEE, 0, 0);
      map_walk(36'h0_0000_3000, VA2, 25'h0000456, 25'h0000789, 24'h123456, 0, 1);
      map_walk(36'h0_0000_4000, VA3, 25'h0000111, 25'h0000222, 24'h000333, 1, 0);
      map_walk(36'h0_0000_5000, VA3, 25'h0000444, 25'h0000555, 24'h000666, 2, 0);
      map_walk(36'h0_0000_6000, VA3, 25'h0000777, 25'h0000888, 24'h000999, 3, 0);
      map_walk(36'h0_0000_2000, VAM, 25'h1FFFFFF, 25'h1FFFFFE, 24'hFFFFFF, 0, 0);
      gap(3);
      rst = 0;
      gap(2);

      // basic walk
      issue(VA1, 36'h0_0000_1000);
      wait_done();
      chk(paddr == 36'hC0_FFEE_ABC && !fault, "R5 basic walk", paddr, 36'hC0_FFEE_ABC);
      gap(2);

      // unaligned root bits and junk entry bits
      issue(VA2, 36'h0_0000_300F);
      wait_done();
      chk(paddr == 36'h12_3456_123 && !fault, "R10 spare entry bits", paddr, 36'h12_3456_123);
      gap(1);

      // faults at each level
      issue(VA3, 36'h0_0000_4000);
      wait_done();
      chk(fault && fault_level == 2'd1 && paddr == 36'h12_3456_123, "R6 level1 fault",
          {fault, fault_level}, 3'b101);
      gap(1);
      issue(VA3, 36'h0_0000_5000);
      wait_done();
      chk(fault && fault_level == 2'd2, "R6 level2 fault", {fault, fault_level}, 3'b110);
      gap(1);
      issue(VA3, 36'h0_0000_6000);
      wait_done();
      chk(fault && fault_level == 2'd3, "R6 level3 fault", {fault, fault_level}, 3'b111);

      // back to back: new request in the done cycle
      chk(done && req_ready, "R12 ready in done cycle", {done, req_ready}, 2'b11);
      issue(VAM, 36'h0_0000_2000);
      chk(!req_ready, "R12 accepted in done cycle", req_ready, 0);
      wait_done();
      chk(paddr == 36'hF_FFFF_FFFF && !fault, "R5 all-ones boundary", paddr, 36'hF_FFFF_FFFF);
      gap(2);

      // requests while busy are ignored
      issue(VA1, 36'h0_0000_1000);
      req_valid = 1; req_vaddr = VA3; root_base = 36'h0_0000_4000;
      gap(2);
      req_valid = 0;
      wait_done();
      chk(paddr == 36'hC0_FFEE_ABC && !fault, "R9 busy request ignored", paddr, 36'hC0_FFEE_ABC);
      gap(2);

      // reset in the middle of a walk, then a stray response
      issue(VA2, 36'h0_0000_3000);
      gap(2);
      rst = 1;
      gap(2);
      rst = 0;
      stray_req = 1;
      gap(4);
      chk(!done && req_ready && paddr == 0, "R11 stray response ignored", {done, req_ready}, 2'b01);
      issue(VA2, 36'h0_0000_3000);
      wait_done();
      chk(paddr == 36'h12_3456_123, "R11 walk after reset", paddr, 36'h12_3456_123);
      gap(4);
      finish_run();
   end

endmodule